// File: doc/BRIEF.md
# Consumer Clock Source Selector with Post-Divider

This block feeds six on-chip clock consumers. Each consumer either takes its clock from one of eight source codes or is switched off. The usable sources are an auxiliary PLL tick stream and six generator tick streams. The selected stream is then divided by a small ratio taken from a four-entry table, and the contents of that table depend on a variant input. Every input and output is a one-cycle tick inside a single system clock domain, so a "clock" here is a stream of tick pulses.

All selection state sits in one 32-bit source-select word, which is visible on `sel_word`. Software changes the word through single-cycle commands: pick a source, enable, disable, or set the divider index. For each consumer the block keeps a remembered source. Disabling a consumer and enabling it again therefore brings back the source it had before. At reset the word is loaded from `boot_word`.

Top module: `clk_src_mux`

## Requirements
- R1: Consumer i (0..5) owns bits 5i+4..5i of `sel_word`: bits 4:2 of the field are its source code and bits 1:0 are its divider index. Reset loads `boot_word` into `sel_word`, including bits 31:30, which commands never change. During and just after reset, `con_tick` is all zero.
- R2: Source code 0 means off, 1 selects `aux_tick`, and codes 2 to 7 select `gen_tick[0]` to `gen_tick[5]`. An enabled consumer gives one `con_tick` pulse per N selected input ticks, where N is its ratio.
- R3: The divider index picks the ratio. With `ext_mode`=0 the ratios for indices 0,1,2,3 are 1,4,1,2. With `ext_mode`=1 they are 1,4,3,2.
- R4: Disable (op 2) sets the consumer's source code to 0 and leaves its divider bits as they were. From the second cycle after the command, `con_tick` for that consumer stays low.
- R5: Enable (op 1) writes the consumer's remembered source code into its field.
- R6: If a consumer's source code in `boot_word` is 0 at reset, its remembered source becomes 1 and its `con_en` bit is low.
- R7: Set-source (op 0, `cmd_arg` = 0..6, code = arg+1) always updates the remembered source. It writes the field only when the current source code is nonzero. Otherwise `sel_word` does not change.
- R8: A set-source with `cmd_arg`=7 has no effect. A command with `cmd_idx` greater than 5 has no effect.
- R9: Set-divider (op 3) writes `cmd_arg[1:0]` into the consumer's divider bits and leaves its source code as it was.
- R10: `con_en[i]` is high exactly when consumer i's source code is nonzero.
- R11: A new source code takes effect only in a cycle where that consumer's registered output is low. While a switch is pending, the output is forced low, so the output is low in the second cycle after the field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | Selects the extended ratio table |
| boot_word | input | 32 | Value loaded into the select word during reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 set source, 1 enable, 2 disable, 3 set divider |
| cmd_idx | input | 3 | Target consumer |
| cmd_arg | input | 3 | Source index or divider index |
| aux_tick | input | 1 | Auxiliary PLL tick stream |
| gen_tick | input | 6 | Generator tick streams |
| sel_word | output | 32 | Current source-select word |
| con_en | output | 6 | Per-consumer enabled status |
| con_tick | output | 6 | Divided consumer tick streams |

## Verification
The two behaviours that collide are a source switch and a due output pulse. Both can arrive in the cycle after a command rewrites the field. The bench provokes this on a consumer that runs at ratio 1 from a tick that is high in every cycle, so its output is high in every cycle, and then moves it to a generator. The bench expects the pulse already registered to still be visible one cycle after the command. In the following cycle the output must be low, because the pending switch suppresses the pulse, and that is the cycle in which the switch is applied.

// File: rtl/csm_pkg.sv
// Shared definitions for the consumer clock source selector.
// Assumes a two-bit divider index; the ratio table is computed, not stored.
package csm_pkg;

    localparam int RATIO_W = 3;

    typedef enum logic [1:0] {
        OP_SRC = 2'd0,
        OP_EN  = 2'd1,
        OP_DIS = 2'd2,
        OP_DIV = 2'd3
    } csm_op_e;

    // Ratio for a divider index; index 2 differs between the two tables.
    function automatic logic [RATIO_W-1:0] csm_ratio(input logic [1:0] idx,
                                                     input logic       ext);
        case (idx)
            2'd0:    csm_ratio = RATIO_W'(1);
            2'd1:    csm_ratio = RATIO_W'(4);
            2'd2:    csm_ratio = ext ? RATIO_W'(3) : RATIO_W'(1);
            default: csm_ratio = RATIO_W'(2);
        endcase
    endfunction

endpackage

// File: rtl/csm_sel_regs.sv
// Holds the source-select word and a remembered source for each consumer.
// Commands are one cycle each and act on the next clock edge.
// Assumes WORD_W >= NUM_CON*(SRC_W+DIV_W); spare upper bits keep their boot value.
module csm_sel_regs
    import csm_pkg::*;
#(
    parameter int NUM_CON = 6,
    parameter int NUM_GEN = 6,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 2,
    parameter int IDX_W   = 3,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] boot_word,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [SRC_W-1:0]  cmd_arg,
    output logic [WORD_W-1:0] sel_word
);
    localparam int FLD_W  = SRC_W + DIV_W;
    localparam int USED_W = NUM_CON * FLD_W;

    for (genvar i = 0; i < NUM_CON; i++) begin : g_fld
        logic [SRC_W-1:0] src_q;
        logic [DIV_W-1:0] div_q;
        logic [SRC_W-1:0] mem_q;
        logic [SRC_W-1:0] boot_src;
        logic             hit;

        assign boot_src = boot_word[i*FLD_W+DIV_W +: SRC_W];
        assign hit      = cmd_valid && (cmd_idx == IDX_W'(i));

        // Field and remembered-source update for consumer i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q <= boot_src;
                div_q <= boot_word[i*FLD_W +: DIV_W];
                mem_q <= (boot_src != '0) ? boot_src : SRC_W'(1);
            end else if (hit) begin
                case (csm_op_e'(cmd_op))
                    OP_SRC: begin
                        if (cmd_arg <= SRC_W'(NUM_GEN)) begin
                            mem_q <= cmd_arg + SRC_W'(1);
                            if (src_q != '0) src_q <= cmd_arg + SRC_W'(1);
                        end
                    end
                    OP_EN:   src_q <= mem_q;
                    OP_DIS:  src_q <= '0;
                    default: div_q <= cmd_arg[DIV_W-1:0];
                endcase
            end
        end

        assign sel_word[i*FLD_W +: FLD_W] = {src_q, div_q};
    end

    if (WORD_W > USED_W) begin : g_spare
        logic [WORD_W-USED_W-1:0] spare_q;
        // Spare upper bits: loaded at reset, never written by commands.
        always_ff @(posedge clk) begin
            if (!rst_n) spare_q <= boot_word[WORD_W-1:USED_W];
        end
        assign sel_word[WORD_W-1:USED_W] = spare_q;
    end

endmodule

// File: rtl/csm_consumer.sv
// One consumer path: source mux, switch gating and post-divider.
// A new source code is taken only while the registered output is low, and a
// pending switch forces the output low. Assumes ratios fit in CNT_W bits + 1.
module csm_consumer
    import csm_pkg::*;
#(
    parameter int NUM_GEN = 6,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 2,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [SRC_W-1:0]   src_code,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic               aux_tick,
    input  logic [NUM_GEN-1:0] gen_tick,
    output logic               tick_out
);
    localparam int NUM_SRC = 1 << SRC_W;

    logic [SRC_W-1:0]   act_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tick_q;
    logic [NUM_SRC-1:0] src_vec;
    logic               in_tick;
    logic [RATIO_W-1:0] ratio;
    logic [CNT_W-1:0]   last_cnt;

    // Place the inputs at their source codes; code 0 carries no ticks.
    always_comb begin
        src_vec    = '0;
        src_vec[1] = aux_tick;
        for (int g = 0; g < NUM_GEN; g++) src_vec[g+2] = gen_tick[g];
    end

    assign in_tick  = src_vec[act_q];
    assign ratio    = csm_ratio(div_sel, ext_mode);
    assign last_cnt = CNT_W'(ratio - RATIO_W'(1));

    // Switch gating, then counting of the applied source's ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (act_q != src_code) begin
            tick_q <= 1'b0;
            if (!tick_q) begin
                act_q <= src_code;
                cnt_q <= '0;
            end
        end else if (act_q == '0) begin
            tick_q <= 1'b0;
            cnt_q  <= '0;
        end else if (in_tick) begin
            if (cnt_q >= last_cnt) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_out = tick_q;

endmodule

// File: rtl/clk_src_mux.sv
// Top of the consumer clock source selector: one select word, six consumers.
// Assumes all tick inputs are synchronous to clk and at most one per cycle.
module clk_src_mux
    import csm_pkg::*;
#(
    parameter int NUM_CON = 6,
    parameter int NUM_GEN = 6,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 2,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 2,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [WORD_W-1:0]  boot_word,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [SRC_W-1:0]   cmd_arg,
    input  logic               aux_tick,
    input  logic [NUM_GEN-1:0] gen_tick,
    output logic [WORD_W-1:0]  sel_word,
    output logic [NUM_CON-1:0] con_en,
    output logic [NUM_CON-1:0] con_tick
);
    localparam int FLD_W = SRC_W + DIV_W;

    csm_sel_regs #(
        .NUM_CON(NUM_CON), .NUM_GEN(NUM_GEN), .SRC_W(SRC_W),
        .DIV_W(DIV_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_word(boot_word),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .sel_word(sel_word)
    );

    for (genvar i = 0; i < NUM_CON; i++) begin : g_con
        logic [SRC_W-1:0] src_code;
        logic [DIV_W-1:0] div_sel;

        assign src_code  = sel_word[i*FLD_W+DIV_W +: SRC_W];
        assign div_sel   = sel_word[i*FLD_W +: DIV_W];
        assign con_en[i] = (src_code != '0);

        csm_consumer #(
            .NUM_GEN(NUM_GEN), .SRC_W(SRC_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
        ) u_con (
            .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
            .src_code(src_code), .div_sel(div_sel),
            .aux_tick(aux_tick), .gen_tick(gen_tick), .tick_out(con_tick[i])
        );
    end

endmodule

// File: rtl/clk_src_mux_chk.sv
// Assertion checker for clk_src_mux, attached with bind below.
// Assumes the default field layout (3-bit source, 2-bit divider index).
module clk_src_mux_chk
    import csm_pkg::*;
#(
    parameter int NUM_CON = 6,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 2,
    parameter int IDX_W   = 3,
    parameter int WORD_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic [IDX_W-1:0]   cmd_idx,
    input logic [SRC_W-1:0]   cmd_arg,
    input logic [WORD_W-1:0]  sel_word,
    input logic [NUM_CON-1:0] con_en,
    input logic [NUM_CON-1:0] con_tick
);
    localparam int FLD_W = SRC_W + DIV_W;

    logic [WORD_W-1:0]  prev_word_q;
    logic [NUM_CON-1:0] prev_dis_q;
    logic               live_q;
    logic [NUM_CON-1:0] src_chg;
    logic               idx_ok;

    function automatic logic [SRC_W-1:0] f_src(input logic [WORD_W-1:0] w,
                                               input logic [IDX_W-1:0]  k);
        f_src = SRC_W'(w >> (int'(k) * FLD_W + DIV_W));
    endfunction

    function automatic logic [DIV_W-1:0] f_div(input logic [WORD_W-1:0] w,
                                               input logic [IDX_W-1:0]  k);
        f_div = DIV_W'(w >> (int'(k) * FLD_W));
    endfunction

    // History of the word and of the disabled set, valid once reset has ended.
    always_ff @(posedge clk) begin
        prev_word_q <= sel_word;
        if (!rst_n) begin
            prev_dis_q <= '0;
            live_q     <= 1'b0;
        end else begin
            prev_dis_q <= ~con_en;
            live_q     <= 1'b1;
        end
    end

    // Per-consumer flag: source code differs from last cycle.
    always_comb begin
        for (int i = 0; i < NUM_CON; i++)
            src_chg[i] = live_q &&
                (f_src(sel_word, IDX_W'(i)) != f_src(prev_word_q, IDX_W'(i)));
    end

    assign idx_ok = (cmd_idx < IDX_W'(NUM_CON));

    // R8
    bad_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !idx_ok) |=> $stable(sel_word));

    // R4
    dis_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idx_ok && csm_op_e'(cmd_op) == OP_DIS)
        |=> (f_src(sel_word, $past(cmd_idx)) == '0));

    // R5
    en_sets_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idx_ok && csm_op_e'(cmd_op) == OP_EN)
        |=> (f_src(sel_word, $past(cmd_idx)) != '0));

    // R9
    div_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idx_ok && csm_op_e'(cmd_op) == OP_DIV)
        |=> (f_div(sel_word, $past(cmd_idx)) == $past(cmd_arg[DIV_W-1:0])));

    // R4
    off_output_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~con_en & prev_dis_q)) |-> ((~con_en & prev_dis_q & con_tick) == '0));

    // R11
    switch_gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_chg) |=> ((con_tick & $past(src_chg)) == '0));

endmodule

bind clk_src_mux clk_src_mux_chk #(
    .NUM_CON(NUM_CON), .SRC_W(SRC_W), .DIV_W(DIV_W),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .sel_word(sel_word),
    .con_en(con_en), .con_tick(con_tick)
);

// File: tb/clk_src_mux_bench.sv
// Self-checking bench: a vector table of commands, each followed by a rate
// measurement of all six consumers, then directed reset and switch tests.
module clk_src_mux_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 5040;
    localparam int SETTLE     = 20;
    localparam int NVEC       = 13;
    localparam logic [31:0] BOOT =
        {2'b10, 5'd23, 5'd0, 5'd30, 5'd13, 5'd4, 5'd3};

    // {ext, op, idx, arg}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 2'd1, 3'd0, 3'd0},
        {1'b0, 2'd0, 3'd4, 3'd2},
        {1'b0, 2'd1, 3'd4, 3'd0},
        {1'b0, 2'd0, 3'd1, 3'd5},
        {1'b1, 2'd3, 3'd1, 3'd2},
        {1'b1, 2'd2, 3'd2, 3'd0},
        {1'b1, 2'd0, 3'd3, 3'd7},
        {1'b1, 2'd3, 3'd6, 3'd1},
        {1'b1, 2'd1, 3'd2, 3'd0},
        {1'b0, 2'd3, 3'd3, 3'd1},
        {1'b0, 2'd2, 3'd5, 3'd0},
        {1'b0, 2'd0, 3'd5, 3'd0},
        {1'b0, 2'd1, 3'd5, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [31:0] boot_word = BOOT;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [2:0]  cmd_arg = '0;
    logic        aux_tick = 1'b1;
    logic [5:0]  gen_tick = '0;
    logic [31:0] sel_word;
    logic [5:0]  con_en;
    logic [5:0]  con_tick;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] mword;
    int mshadow [6];
    int gcnt [6];

    clk_src_mux u_clk_src_mux (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .boot_word(boot_word),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .aux_tick(aux_tick), .gen_tick(gen_tick),
        .sel_word(sel_word), .con_en(con_en), .con_tick(con_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Generator j ticks once every j+2 cycles, driven on the falling edge.
    initial for (int j = 0; j < 6; j++) gcnt[j] = 0;
    always @(negedge clk) begin
        for (int j = 0; j < 6; j++) begin
            gen_tick[j] <= (gcnt[j] == 0);
            gcnt[j]     <= (gcnt[j] == j + 1) ? 0 : gcnt[j] + 1;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string vtag(input int v);
        case (v)
            0:       return "R6";
            1, 3, 11: return "R7";
            2, 8, 12: return "R5";
            4:       return "R3";
            5, 10:   return "R4";
            6, 7:    return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int ratio_of(input int d, input logic ext);
        case (d)
            0: return 1;
            1: return 4;
            2: return ext ? 3 : 1;
            default: return 2;
        endcase
    endfunction

    function automatic int src_of(input logic [31:0] w, input int i);
        return int'(w[i*5+2 +: 3]);
    endfunction

    task automatic model_reset();
        mword = boot_word;
        for (int i = 0; i < 6; i++)
            mshadow[i] = (src_of(mword, i) != 0) ? src_of(mword, i) : 1;
    endtask

    task automatic model_cmd(input int op, input int idx, input int arg);
        if (idx > 5) return;
        case (op)
            0: if (arg <= 6) begin
                   mshadow[idx] = arg + 1;
                   if (src_of(mword, idx) != 0) mword[idx*5+2 +: 3] = 3'(arg + 1);
               end
            1: mword[idx*5+2 +: 3] = 3'(mshadow[idx]);
            2: mword[idx*5+2 +: 3] = 3'd0;
            default: mword[idx*5 +: 2] = 2'(arg);
        endcase
    endtask

    task automatic send(input int op, input int idx, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_idx   = 3'(idx);
        cmd_arg   = 3'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        model_cmd(op, idx, arg);
    endtask

    // Count pulses of every consumer over WIN cycles and compare with the model.
    task automatic measure();
        int cnt [6];
        logic [5:0] exp_en;
        for (int i = 0; i < 6; i++) cnt[i] = 0;
        repeat (SETTLE) @(negedge clk);
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            for (int i = 0; i < 6; i++) cnt[i] += int'(con_tick[i]);
        end
        for (int i = 0; i < 6; i++) begin
            int s = src_of(mword, i);
            int r = ratio_of(int'(mword[i*5 +: 2]), ext_mode);
            exp_en[i] = (s != 0);
            // R2 R3: pulse count = input ticks / ratio; source code s ticks every s cycles
            check(i == 0 ? "R2 rate" : "R3 rate", cnt[i], (s == 0) ? 0 : WIN / (s * r));
        end
        check("R10 con_en", con_en, exp_en);
    endtask

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        check("R1 reset con_tick", con_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", sel_word, BOOT);
        check("R6 reset con_en", con_en, 6'b101110);
        check("R1 post-reset con_tick", con_tick, 0);
        measure();

        for (int v = 0; v < NVEC; v++) begin
            ext_mode = VEC[v][8];
            send(int'(VEC[v][7:6]), int'(VEC[v][5:3]), int'(VEC[v][2:0]));
            check(vtag(v), sel_word, mword);
            measure();
        end

        // R11: ratio 1 on the always-high auxiliary tick, then switch away.
        send(0, 1, 0);
        send(3, 1, 0);
        repeat (10) @(negedge clk);
        check("R2 continuous", con_tick[1], 1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_idx = 3'd1; cmd_arg = 3'd6;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_cmd(0, 1, 6);
        check("R11 old pulse still out", con_tick[1], 1);
        @(negedge clk);
        check("R11 forced low at switch", con_tick[1], 0);
        check("R7 word after switch", sel_word, mword);

        // R6: reset again, enable a consumer that booted with source 0.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1 re-reset word", sel_word, BOOT);
        send(1, 4, 0);
        check("R6 default source", src_of(sel_word, 4), 1);
        check("R10 enabled after default", con_en[4], 1);
        finish_run();
    end

endmodule